// File: doc/BRIEF.md
# Trust Propagation Checker

This block sits beside a host processor pipeline and watches every retiring instruction. For each one it receives the program counter, up to two source register numbers, an optional destination register number, and flags for loads and stores with the memory address they touch. It keeps a shadow register file with one trusted bit per architectural register. It decides, per instruction, whether trust moves to the destination, is cleared there, whether a software second-level check is needed, or whether an alarm must be raised.

The tags for instructions and memory live outside the block. A combinational lookup port is driven with the program counter and the data address of the instruction in the fetch stage. It answers with whether that instruction is trusted and whether that memory location is trusted and critical. Trust updates for memory locations leave the block on a tag write port. Register trust is written back into the shadow file in the last stage. The checker has four stages: fetch (instruction trust lookup), register (operand trust read, with forwarding from the two later stages), check (rule decision) and writeback (events, tag updates, shadow write).

The rule decision yields one of five actions. NONE applies when there is no destination. L2_KEEP means a second-level request with tags left unchanged. L2_SET means a second-level request with the destination marked trusted. ALARM raises an alarm. CLEAR removes trust from the destination. The pipeline moves by three rules: advance when idle, hold the fetch, register and check stages during a stall, and empty them on a flush.

Top module: `trust_chk_top`

## Requirements
- R1: A trusted instruction whose operands are all trusted and whose destination is critical produces a second-level request and no tag write.
- R2: A trusted instruction whose operands are all trusted and whose destination is not critical produces a second-level request and marks the destination trusted: the shadow register for a register result, or a tag write with mt_trusted=1 for a store.
- R3: A trusted instruction with any untrusted enabled operand raises an alarm, critical destination or not, and changes no tag.
- R4: An untrusted instruction with a critical destination raises an alarm whatever its operand trust.
- R5: An untrusted instruction with a non-critical destination clears the destination's trust (shadow register, or tag write with mt_trusted=0) and raises no event.
- R6: An instruction accepted at a clock edge without stall shows its event on alarm or l2_req, and its tag write, in the cycle after the third following edge. Events are one-cycle pulses, alarm and l2_req are never high together, and evt_pc carries the instruction's program counter during an event and zero otherwise.
- R7: The operand trust of an instruction reflects the results of older instructions still in the check or writeback stage.
- R8: After reset every shadow register except register zero is untrusted and no event or tag write is pending.
- R9: Register zero always reads as trusted. A trust write to it has no effect, though its event still occurs.
- R10: While host_stall is high, the fetch, register and check stages hold, no event or tag write is produced, and in_valid is ignored. Work resumes where it stopped once the stall is released.
- R11: host_flush discards the fetch, register and check stages. Their instructions produce no event and update no tag.
- R12: An instruction with neither a register destination nor a store produces no event and no tag change.
- R13: For a load, the trust of the loaded memory location counts as an operand. For a store, destination criticality comes from the lookup. Register destinations are never critical. The lookup port carries the program counter and address of the instruction in the cycle after its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A retiring instruction is presented |
| in_pc | input | PC_W | Program counter of the instruction |
| in_rs1 | input | RIDX_W | First source register number |
| in_rs1_en | input | 1 | First source is used |
| in_rs2 | input | RIDX_W | Second source register number |
| in_rs2_en | input | 1 | Second source is used |
| in_rd | input | RIDX_W | Destination register number |
| in_rd_en | input | 1 | Instruction writes a register |
| in_is_store | input | 1 | Instruction writes memory at in_addr |
| in_is_load | input | 1 | Instruction reads memory at in_addr |
| in_addr | input | ADDR_W | Data address of a load or store |
| host_stall | input | 1 | Host pipeline stalled |
| host_flush | input | 1 | Host pipeline flushed |
| lk_pc | output | PC_W | Lookup: program counter to classify |
| lk_addr | output | ADDR_W | Lookup: data address to classify |
| lk_pc_trusted | input | 1 | Lookup answer: instruction is trusted |
| lk_addr_trusted | input | 1 | Lookup answer: data location is trusted |
| lk_addr_critical | input | 1 | Lookup answer: data location is critical |
| alarm | output | 1 | One-cycle alarm pulse |
| l2_req | output | 1 | One-cycle second-level check request |
| evt_pc | output | PC_W | Program counter of the instruction behind an event |
| mt_we | output | 1 | Memory tag write strobe |
| mt_addr | output | ADDR_W | Memory tag write address |
| mt_trusted | output | 1 | New trusted value for the memory tag |

## Verification
The bench builds the checker with 16-bit program counters and addresses and a 16-entry shadow file. This keeps register numbers small enough that one stimulus table can trust, clear and reuse most registers in a single pass, including register zero. The narrow address lets the bench's own lookup model classify locations from two address bits and instructions from the top program counter bit. Every combination in the rule table can then be reached from short hand-picked values. Back-to-back sequences reach both forwarding paths, and stall and flush windows aimed at known stages show the hold and discard behaviour on the event outputs.

// File: rtl/trust_chk_pkg.sv
package trust_chk_pkg;

    // Outcome of the rule check for one instruction
    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_L2_KEEP = 3'd1,
        ACT_L2_SET  = 3'd2,
        ACT_ALARM   = 3'd3,
        ACT_CLEAR   = 3'd4
    } act_e;

endpackage

// File: rtl/trust_rule.sv
module trust_rule
    import trust_chk_pkg::*;
(
    input  logic valid,
    input  logic has_dst,
    input  logic inst_trusted,
    input  logic ops_trusted,
    input  logic dst_critical,
    output act_e act
);

    always_comb begin
        act = ACT_NONE;
        if (valid && has_dst) begin
            unique case ({inst_trusted, ops_trusted})
                2'b11:   act = dst_critical ? ACT_L2_KEEP : ACT_L2_SET;
                2'b10:   act = ACT_ALARM;
                default: act = dst_critical ? ACT_ALARM : ACT_CLEAR;
            endcase
        end
    end

endmodule

// File: rtl/trust_shadow_rf.sv
module trust_shadow_rf #(
    parameter int REG_N  = 32,
    parameter int RIDX_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] ra_idx,
    output logic              ra_trust,
    input  logic [RIDX_W-1:0] rb_idx,
    output logic              rb_trust,
    input  logic              we,
    input  logic [RIDX_W-1:0] w_idx,
    input  logic              w_trust
);

    logic [REG_N-1:0] bits;

    for (genvar g = 0; g < REG_N; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign bits[g] = 1'b1;
        end else begin : g_live
            logic q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= 1'b0;
                else if (we && (w_idx == RIDX_W'(g)))
                    q <= w_trust;
            end
            assign bits[g] = q;
        end
    end

    assign ra_trust = bits[ra_idx];
    assign rb_trust = bits[rb_idx];

    AST_RF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (w_idx != '0)) |=> (bits[$past(w_idx)] == $past(w_trust))); // R2

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (w_idx == '0)) |=> bits[0]); // R9

endmodule

// File: rtl/trust_chk_top.sv
module trust_chk_top
    import trust_chk_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32,
    parameter int REG_N  = 32,
    localparam int RIDX_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [RIDX_W-1:0] in_rs1,
    input  logic              in_rs1_en,
    input  logic [RIDX_W-1:0] in_rs2,
    input  logic              in_rs2_en,
    input  logic [RIDX_W-1:0] in_rd,
    input  logic              in_rd_en,
    input  logic              in_is_store,
    input  logic              in_is_load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              host_stall,
    input  logic              host_flush,
    output logic [PC_W-1:0]   lk_pc,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_pc_trusted,
    input  logic              lk_addr_trusted,
    input  logic              lk_addr_critical,
    output logic              alarm,
    output logic              l2_req,
    output logic [PC_W-1:0]   evt_pc,
    output logic              mt_we,
    output logic [ADDR_W-1:0] mt_addr,
    output logic              mt_trusted
);

    // Fetch stage
    logic              f_valid, f_rs1_en, f_rs2_en, f_rd_en, f_store, f_load;
    logic [PC_W-1:0]   f_pc;
    logic [RIDX_W-1:0] f_rs1, f_rs2, f_rd;
    logic [ADDR_W-1:0] f_addr;
    // Register stage
    logic              r_valid, r_rs1_en, r_rs2_en, r_rd_en, r_store;
    logic              r_inst_tr, r_mem_tr, r_crit;
    logic [PC_W-1:0]   r_pc;
    logic [RIDX_W-1:0] r_rs1, r_rs2, r_rd;
    logic [ADDR_W-1:0] r_addr;
    // Check stage
    logic              c_valid, c_rd_en, c_store, c_inst_tr, c_ops_tr, c_crit;
    logic [PC_W-1:0]   c_pc;
    logic [RIDX_W-1:0] c_rd;
    logic [ADDR_W-1:0] c_addr;
    act_e              c_act;
    // Writeback stage
    logic              w_valid, w_rd_en, w_store;
    logic [PC_W-1:0]   w_pc;
    logic [RIDX_W-1:0] w_rd;
    logic [ADDR_W-1:0] w_addr;
    act_e              w_act;

    // Lookup port serves the fetch stage
    assign lk_pc   = f_pc;
    assign lk_addr = f_addr;

    trust_rule u_rule (
        .valid        (c_valid),
        .has_dst      (c_store | c_rd_en),
        .inst_trusted (c_inst_tr),
        .ops_trusted  (c_ops_tr),
        .dst_critical (c_crit),
        .act          (c_act)
    );

    // Register trust updates produced by the check and writeback stages
    logic c_fwd, c_fwd_val, w_fwd, w_fwd_val;
    assign c_fwd     = c_valid && !c_store && c_rd_en && (c_rd != '0) &&
                       ((c_act == ACT_L2_SET) || (c_act == ACT_CLEAR));
    assign c_fwd_val = (c_act == ACT_L2_SET);
    assign w_fwd     = w_valid && !w_store && w_rd_en && (w_rd != '0) &&
                       ((w_act == ACT_L2_SET) || (w_act == ACT_CLEAR));
    assign w_fwd_val = (w_act == ACT_L2_SET);

    logic rf_a, rf_b;
    trust_shadow_rf #(.REG_N(REG_N), .RIDX_W(RIDX_W)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (r_rs1),
        .ra_trust (rf_a),
        .rb_idx   (r_rs2),
        .rb_trust (rf_b),
        .we       (w_fwd),
        .w_idx    (w_rd),
        .w_trust  (w_fwd_val)
    );

    // Youngest older result wins: check stage before writeback stage
    function automatic logic fwd_trust(input logic [RIDX_W-1:0] idx, input logic rf_val,
                                       input logic cf, input logic [RIDX_W-1:0] crd,
                                       input logic cv, input logic wf,
                                       input logic [RIDX_W-1:0] wrd, input logic wv);
        if (idx == '0)               return 1'b1;
        else if (cf && (crd == idx)) return cv;
        else if (wf && (wrd == idx)) return wv;
        else                         return rf_val;
    endfunction

    logic op_a_ok, op_b_ok, r_ops_tr;
    always_comb begin
        op_a_ok  = !r_rs1_en || fwd_trust(r_rs1, rf_a, c_fwd, c_rd, c_fwd_val,
                                          w_fwd, w_rd, w_fwd_val);
        op_b_ok  = !r_rs2_en || fwd_trust(r_rs2, rf_b, c_fwd, c_rd, c_fwd_val,
                                          w_fwd, w_rd, w_fwd_val);
        r_ops_tr = op_a_ok && op_b_ok && r_mem_tr;
    end

    // Stage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_valid <= 1'b0; r_valid <= 1'b0; c_valid <= 1'b0; w_valid <= 1'b0;
            f_pc <= '0; f_rs1 <= '0; f_rs2 <= '0; f_rd <= '0; f_addr <= '0;
            f_rs1_en <= 1'b0; f_rs2_en <= 1'b0; f_rd_en <= 1'b0;
            f_store <= 1'b0; f_load <= 1'b0;
            r_pc <= '0; r_rs1 <= '0; r_rs2 <= '0; r_rd <= '0; r_addr <= '0;
            r_rs1_en <= 1'b0; r_rs2_en <= 1'b0; r_rd_en <= 1'b0; r_store <= 1'b0;
            r_inst_tr <= 1'b0; r_mem_tr <= 1'b0; r_crit <= 1'b0;
            c_pc <= '0; c_rd <= '0; c_addr <= '0; c_rd_en <= 1'b0; c_store <= 1'b0;
            c_inst_tr <= 1'b0; c_ops_tr <= 1'b0; c_crit <= 1'b0;
            w_pc <= '0; w_rd <= '0; w_addr <= '0; w_rd_en <= 1'b0; w_store <= 1'b0;
            w_act <= ACT_NONE;
        end else if (host_flush) begin
            f_valid <= 1'b0; r_valid <= 1'b0; c_valid <= 1'b0; w_valid <= 1'b0;
        end else if (host_stall) begin
            w_valid <= 1'b0;
        end else begin
            f_valid  <= in_valid;
            f_pc     <= in_pc;
            f_rs1    <= in_rs1;    f_rs1_en <= in_rs1_en;
            f_rs2    <= in_rs2;    f_rs2_en <= in_rs2_en;
            f_rd     <= in_rd;     f_rd_en  <= in_rd_en;
            f_store  <= in_is_store;
            f_load   <= in_is_load;
            f_addr   <= in_addr;

            r_valid   <= f_valid;
            r_pc      <= f_pc;
            r_rs1     <= f_rs1;    r_rs1_en <= f_rs1_en;
            r_rs2     <= f_rs2;    r_rs2_en <= f_rs2_en;
            r_rd      <= f_rd;     r_rd_en  <= f_rd_en && !f_store;
            r_store   <= f_store;
            r_addr    <= f_addr;
            r_inst_tr <= lk_pc_trusted;
            r_mem_tr  <= f_load ? lk_addr_trusted : 1'b1;
            r_crit    <= f_store && lk_addr_critical;

            c_valid   <= r_valid;
            c_pc      <= r_pc;
            c_rd      <= r_rd;     c_rd_en <= r_rd_en;
            c_store   <= r_store;
            c_addr    <= r_addr;
            c_inst_tr <= r_inst_tr;
            c_ops_tr  <= r_ops_tr;
            c_crit    <= r_crit;

            w_valid <= c_valid;
            w_pc    <= c_pc;
            w_act   <= c_act;
            w_rd    <= c_rd;       w_rd_en <= c_rd_en;
            w_store <= c_store;
            w_addr  <= c_addr;
        end
    end

    // Writeback stage outputs
    always_comb begin
        alarm      = w_valid && (w_act == ACT_ALARM);
        l2_req     = w_valid && ((w_act == ACT_L2_KEEP) || (w_act == ACT_L2_SET));
        evt_pc     = (alarm || l2_req) ? w_pc : '0;
        mt_we      = w_valid && w_store && ((w_act == ACT_L2_SET) || (w_act == ACT_CLEAR));
        mt_addr    = mt_we ? w_addr : '0;
        mt_trusted = mt_we && (w_act == ACT_L2_SET);
    end

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(alarm && l2_req)); // R6

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> ($past(c_valid) && !$past(host_stall) && !$past(host_flush))); // R6

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_stall |=> !(alarm || l2_req || mt_we)); // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stall && !host_flush) |=> ($stable(f_valid) && $stable(f_pc))); // R10

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_flush |=> !(alarm || l2_req || mt_we || r_valid || c_valid)); // R11

    AST_UNTRUSTED_CRIT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_valid && c_store && !c_inst_tr && c_crit) |-> (c_act == ACT_ALARM)); // R4

    AST_BAD_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (c_valid && (c_store || c_rd_en) && c_inst_tr && !c_ops_tr) |-> (c_act == ACT_ALARM)); // R3

    AST_NO_TAG_ON_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        mt_we |-> !alarm); // R3

endmodule

// File: tb/sim_trust_chk_top.sv
`timescale 1ns/1ps
module sim_trust_chk_top;

    localparam int PC_W = 16, ADDR_W = 16, REG_N = 16, RIDX_W = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, in_valid, in_rs1_en, in_rs2_en, in_rd_en, in_is_store, in_is_load;
    logic [PC_W-1:0] in_pc, lk_pc, evt_pc;
    logic [RIDX_W-1:0] in_rs1, in_rs2, in_rd;
    logic [ADDR_W-1:0] in_addr, lk_addr, mt_addr;
    logic host_stall, host_flush, alarm, l2_req, mt_we, mt_trusted;
    logic lk_pc_trusted, lk_addr_trusted, lk_addr_critical;

    // Bench tag model: pc[15] marks trusted code, addr[15] critical, addr[14] trusted data
    assign lk_pc_trusted    = lk_pc[15];
    assign lk_addr_critical = lk_addr[15];
    assign lk_addr_trusted  = lk_addr[14];

    trust_chk_top #(.PC_W(PC_W), .ADDR_W(ADDR_W), .REG_N(REG_N)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
        .in_rs1(in_rs1), .in_rs1_en(in_rs1_en), .in_rs2(in_rs2), .in_rs2_en(in_rs2_en),
        .in_rd(in_rd), .in_rd_en(in_rd_en), .in_is_store(in_is_store),
        .in_is_load(in_is_load), .in_addr(in_addr), .host_stall(host_stall),
        .host_flush(host_flush), .lk_pc(lk_pc), .lk_addr(lk_addr),
        .lk_pc_trusted(lk_pc_trusted), .lk_addr_trusted(lk_addr_trusted),
        .lk_addr_critical(lk_addr_critical), .alarm(alarm), .l2_req(l2_req),
        .evt_pc(evt_pc), .mt_we(mt_we), .mt_addr(mt_addr), .mt_trusted(mt_trusted)
    );

    typedef struct packed {
        logic [15:0] pc;
        logic [3:0]  rs1; logic e1;
        logic [3:0]  rs2; logic e2;
        logic [3:0]  rd;  logic ed;
        logic        st;  logic ld;
        logic [15:0] addr;
        logic        x_alarm, x_l2, x_mtwe, x_mtt;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{16'h8000, 4'd0, 1'b0, 4'd0, 1'b0, 4'd1,  1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, "R2"},
        '{16'h8004, 4'd1, 1'b1, 4'd5, 1'b0, 4'd2,  1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, "R2"},
        '{16'h8008, 4'd5, 1'b1, 4'd0, 1'b0, 4'd3,  1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{16'h000C, 4'd1, 1'b1, 4'd0, 1'b0, 4'd1,  1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R5"},
        '{16'h8010, 4'd1, 1'b1, 4'd0, 1'b0, 4'd4,  1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R5"},
        '{16'h8014, 4'd2, 1'b1, 4'd0, 1'b1, 4'd0,  1'b0, 1'b1, 1'b0, 16'h8100, 1'b0, 1'b1, 1'b0, 1'b0, "R1"},
        '{16'h8018, 4'd2, 1'b1, 4'd0, 1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b1, 1'b1, 1'b1, "R2"},
        '{16'h001C, 4'd2, 1'b1, 4'd0, 1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 16'h8200, 1'b1, 1'b0, 1'b0, 1'b0, "R4"},
        '{16'h0020, 4'd5, 1'b1, 4'd0, 1'b0, 4'd0,  1'b0, 1'b1, 1'b0, 16'h0200, 1'b0, 1'b0, 1'b1, 1'b0, "R5"},
        '{16'h0024, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R9"},
        '{16'h8028, 4'd0, 1'b1, 4'd0, 1'b1, 4'd6,  1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, "R9"},
        '{16'h802C, 4'd2, 1'b1, 4'd3, 1'b1, 4'd7,  1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R3"},
        '{16'h8030, 4'd2, 1'b1, 4'd0, 1'b0, 4'd8,  1'b1, 1'b0, 1'b1, 16'h4000, 1'b0, 1'b1, 1'b0, 1'b0, "R13"},
        '{16'h8034, 4'd2, 1'b1, 4'd0, 1'b0, 4'd9,  1'b1, 1'b0, 1'b1, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, "R13"},
        '{16'h8038, 4'd5, 1'b1, 4'd0, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R12"},
        '{16'h003C, 4'd2, 1'b1, 4'd0, 1'b0, 4'd6,  1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R5"},
        '{16'h8040, 4'd6, 1'b1, 4'd0, 1'b0, 4'd10, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R5"}
    };

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic drive(input logic [15:0] pc, input logic [3:0] rs1, input logic e1,
                         input logic [3:0] rs2, input logic e2, input logic [3:0] rd,
                         input logic ed, input logic st, input logic ld, input logic [15:0] addr);
        in_valid = 1'b1; in_pc = pc; in_rs1 = rs1; in_rs1_en = e1; in_rs2 = rs2;
        in_rs2_en = e2; in_rd = rd; in_rd_en = ed; in_is_store = st;
        in_is_load = ld; in_addr = addr;
    endtask

    task automatic idle();
        in_valid = 1'b0; in_pc = '0; in_rs1 = '0; in_rs1_en = 1'b0; in_rs2 = '0;
        in_rs2_en = 1'b0; in_rd = '0; in_rd_en = 1'b0; in_is_store = 1'b0;
        in_is_load = 1'b0; in_addr = '0;
    endtask

    task automatic chk_out(input string req, input logic xa, input logic xl,
                           input logic [15:0] xpc, input logic xw,
                           input logic [15:0] xaddr, input logic xt);
        n_checks++;
        if (alarm !== xa || l2_req !== xl || evt_pc !== xpc || mt_we !== xw ||
            mt_addr !== xaddr || mt_trusted !== xt) begin
            n_fail++;
            $display("FAIL %s: got alarm=%b l2=%b pc=%h mtwe=%b mtaddr=%h mtt=%b, expected alarm=%b l2=%b pc=%h mtwe=%b mtaddr=%h mtt=%b",
                     req, alarm, l2_req, evt_pc, mt_we, mt_addr, mt_trusted,
                     xa, xl, xpc, xw, xaddr, xt);
        end
    endtask

    task automatic quiet(input string req);
        chk_out(req, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got run still active, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; host_stall = 1'b0; host_flush = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        quiet("R8 outputs after reset");

        // R8: register 12 untrusted after reset
        drive(16'h8F00, 4'd12, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 16'h0);
        @(negedge clk);
        idle();
        n_checks++;                                  // R13 lookup port in fetch cycle
        if (lk_pc !== 16'h8F00) begin
            n_fail++;
            $display("FAIL R13 lookup pc: got %h expected %h", lk_pc, 16'h8F00);
        end
        repeat (3) @(negedge clk);
        chk_out("R8 reset shadow untrusted", 1'b1, 1'b0, 16'h8F00, 1'b0, 16'h0, 1'b0);

        // Table walk, one instruction in flight at a time
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            drive(v.pc, v.rs1, v.e1, v.rs2, v.e2, v.rd, v.ed, v.st, v.ld, v.addr);
            @(negedge clk);
            idle();
            repeat (3) @(negedge clk);
            chk_out($sformatf("%s vector %0d", v.tag, i), v.x_alarm, v.x_l2,
                    (v.x_alarm || v.x_l2) ? v.pc : 16'h0, v.x_mtwe,
                    v.x_mtwe ? v.addr : 16'h0, v.x_mtt);
            n_checks++;                              // R6 pulse lasts one cycle
            @(negedge clk);
            if (alarm || l2_req || mt_we) begin
                n_fail++;
                $display("FAIL R6 pulse width vector %0d: got alarm=%b l2=%b mtwe=%b expected 0",
                         i, alarm, l2_req, mt_we);
            end
        end

        // R7: back-to-back forwarding from check and writeback stages
        begin
            logic [15:0] pcs [5] = '{16'h8100, 16'h8104, 16'h8108, 16'h010C, 16'h8110};
            logic [3:0]  rs   [5] = '{4'd0, 4'd11, 4'd11, 4'd0, 4'd11};
            logic        es   [5] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
            logic [3:0]  rds  [5] = '{4'd11, 4'd12, 4'd13, 4'd11, 4'd14};
            logic        xa   [5] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
            logic        xl   [5] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
            for (int k = 0; k < 9; k++) begin
                if (k >= 4)
                    chk_out($sformatf("R7 forwarding slot %0d", k - 4), xa[k-4], xl[k-4],
                            (xa[k-4] || xl[k-4]) ? pcs[k-4] : 16'h0, 1'b0, 16'h0, 1'b0);
                if (k < 5) drive(pcs[k], rs[k], es[k], 4'd0, 1'b0, rds[k], 1'b1, 1'b0, 1'b0, 16'h0);
                else idle();
                @(negedge clk);
            end
        end

        // R10: stall holds the pipe and ignores new input
        drive(16'h8200, 4'd0, 1'b0, 4'd0, 1'b0, 4'd15, 1'b1, 1'b0, 1'b0, 16'h0);
        @(negedge clk);
        host_stall = 1'b1;
        drive(16'h0204, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h8000);
        for (int k = 1; k < 7; k++) begin
            if (k > 1) quiet($sformatf("R10 quiet during/after stall %0d", k));
            @(negedge clk);
            if (k == 3) begin host_stall = 1'b0; idle(); end
        end
        chk_out("R10 resumed event", 1'b0, 1'b1, 16'h8200, 1'b0, 16'h0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            quiet("R10 ignored input never alarms");
        end

        // R11: flush discards in-flight entries
        drive(16'h8300, 4'd0, 1'b0, 4'd0, 1'b0, 4'd9, 1'b1, 1'b0, 1'b0, 16'h0);
        @(negedge clk);
        drive(16'h0304, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 16'h8000);
        @(negedge clk);
        idle();
        host_flush = 1'b1;
        @(negedge clk);
        host_flush = 1'b0;
        for (int k = 0; k < 5; k++) begin
            quiet("R11 flushed work silent");
            @(negedge clk);
        end
        drive(16'h8308, 4'd9, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 16'h0);
        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);
        chk_out("R11 flushed write left r9 untrusted", 1'b1, 1'b0, 16'h8308, 1'b0, 16'h0, 1'b0);

        finish_run();
    end

endmodule